// File: doc/BRIEF.md
# DMA Linear Burst Sequencer

This block drives the data phases of a bus-master DMA engine in a network interface. It reads transmit buffers from memory, or writes receive FIFO data into memory, as linear bursts of 32-bit words. A job is started with a direction, a word-aligned start address and the inclusive byte address of the last byte the buffer owns. The sequencer then raises a bus request. On every granted cycle where data can move, it performs one transfer. The address steps by four bytes per transfer, and every lane is enabled for burst transfers.

A burst stops when one of these occurs:
- the programmable burst length is reached;
- the buffer runs out;
- the receive FIFO holds its final word for the packet;
- the grant is withdrawn.

After a transfer that it flags as final, it drops its request for one cycle to release the bus. A receive buffer may end partway through a word. In that case the burst stops one word early, and the tail word is written alone as a non-burst cycle with only the owned lanes enabled. After preemption the sequencer resumes at the next untransferred word. No word is skipped or repeated.

Top module: `dma_burst_seq`

## Requirements
- R1: A burst never holds more transfers than `burst_limit`. A limit of 0 behaves as 1. The burst count restarts after a flagged final transfer.
- R2: Every burst transfer (`xfer`=1, `burst`=1) has `be_n` = 4'b0000.
- R3: Transmit jobs end at the buffer's final word. That transfer is flagged `last`, and `busy` is low the next cycle.
- R4: In receive mode no transfer happens while `rx_words` is 0. A transfer made while `rx_words` is 1 is flagged `last`.
- R5: A receive job never transfers beyond the word holding `buf_end`. The transfer to that word is flagged `last`.
- R6: No transfer happens while `gnt` is low. A withdrawn grant ends the burst, so the count starts from zero on the next grant.
- R7: In the cycle after a transfer flagged `last`, `req` and `xfer` are both low.
- R8: In receive mode with `buf_end[1:0]` not 3, the transfer to the second-to-last word is flagged `last`. The final word is then a single cycle (`burst`=0, `last`=1) with active-low `be_n` = 4'b1110, 4'b1100 or 4'b1000 for `buf_end[1:0]` = 0, 1 or 2.
- R9: The first transfer uses `buf_base` with bits [1:0] cleared. Each later transfer is 4 bytes higher, including across a preemption.
- R10: After reset `busy`, `req` and `xfer` are low and `be_n` is 4'b1111.
- R11: A transmit job always uses burst transfers with all lanes enabled, even when `buf_end[1:0]` is not 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Loads a new job when not busy |
| rx_mode | input | 1 | 1 = receive write, 0 = transmit read |
| buf_base | input | AW | Start byte address of the buffer |
| buf_end | input | AW | Inclusive byte address of the last owned byte |
| burst_limit | input | CW | Maximum transfers per burst |
| rx_words | input | FW | Words the receive FIFO holds for the current packet |
| gnt | input | 1 | Bus grant |
| req | output | 1 | Bus request |
| xfer | output | 1 | A data transfer occurs this cycle |
| burst | output | 1 | The current transfer is part of a linear burst |
| last | output | 1 | Final transfer before the bus is released |
| addr | output | AW | Byte address of the current transfer |
| be_n | output | 4 | Active-low byte enables |
| busy | output | 1 | A job is in progress |

## Verification
Two stop causes can fall in the same cycle.

The first pairing is the burst length limit and the stop one word ahead of a partial receive tail. This is provoked with a limit of 2 on a three-word buffer whose end sits in byte 0. The bench expects exactly one flagged final transfer at that word, followed by a single cycle with mask 4'b1110.

The second pairing is the limit and the buffer end, which coincide on an eight-word transmit buffer with a limit of 4. There the bench counts two released bursts rather than three. The per-cycle monitor checks release, lane use and address continuity in every case.

// File: rtl/dma_burst_seq.sv
module dma_burst_seq #(
  parameter int AW = 32,
  parameter int CW = 8,
  parameter int FW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          rx_mode,
  input  logic [AW-1:0] buf_base,
  input  logic [AW-1:0] buf_end,
  input  logic [CW-1:0] burst_limit,
  input  logic [FW-1:0] rx_words,
  input  logic          gnt,
  output logic          req,
  output logic          xfer,
  output logic          burst,
  output logic          last,
  output logic [AW-1:0] addr,
  output logic [3:0]    be_n,
  output logic          busy
);
  localparam int WW = AW - 2;
  localparam logic [WW-1:0] W_ONE = 1;
  localparam logic [CW:0]   C_ONE = 1;
  localparam logic [CW-1:0] K_ONE = 1;
  localparam logic [FW-1:0] F_ONE = 1;

  logic          busy_q, rx_q, gap_q;
  logic [WW-1:0] wa_q, we_q;
  logic [1:0]    tail_q;
  logic [CW-1:0] cnt_q;
  logic          at_last, partial, single, next_single, data_ok, lim_hit, rx_end;
  logic [3:0]    tail_mask;

  assign at_last     = wa_q == we_q;
  assign partial     = rx_q && tail_q != 2'b11;
  assign single      = at_last && partial;
  assign next_single = partial && (wa_q + W_ONE == we_q);
  assign data_ok     = !rx_q || rx_words != '0;
  assign lim_hit     = ({1'b0, cnt_q} + C_ONE) >= {1'b0, burst_limit};
  assign rx_end      = rx_q && rx_words == F_ONE;

  assign busy  = busy_q;
  assign req   = busy_q && !gap_q;
  assign xfer  = req && gnt && data_ok;
  assign last  = xfer && (lim_hit || at_last || next_single || rx_end);
  assign burst = xfer && !single;
  assign addr  = {wa_q, 2'b00};

  always_comb begin
    case (tail_q)
      2'd0:    tail_mask = 4'b1110;
      2'd1:    tail_mask = 4'b1100;
      2'd2:    tail_mask = 4'b1000;
      default: tail_mask = 4'b0000;
    endcase
  end

  assign be_n = !xfer ? 4'b1111 : (single ? tail_mask : 4'b0000);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      rx_q   <= 1'b0;
      gap_q  <= 1'b0;
      wa_q   <= '0;
      we_q   <= '0;
      tail_q <= 2'b00;
      cnt_q  <= '0;
    end else if (!busy_q) begin
      gap_q <= 1'b0;
      cnt_q <= '0;
      if (start) begin
        busy_q <= 1'b1;
        rx_q   <= rx_mode;
        wa_q   <= buf_base[AW-1:2];
        we_q   <= buf_end[AW-1:2];
        tail_q <= buf_end[1:0];
      end
    end else begin
      gap_q <= last;
      if (xfer) begin
        wa_q <= wa_q + W_ONE;
        if (at_last) busy_q <= 1'b0;
      end
      if (last || !gnt) cnt_q <= '0;
      else if (xfer)    cnt_q <= cnt_q + K_ONE;
    end
  end
endmodule

// File: rtl/dma_burst_seq_chk.sv
module dma_burst_seq_chk #(
  parameter int AW = 32,
  parameter int FW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          gnt,
  input logic          rx_q,
  input logic [FW-1:0] rx_words,
  input logic          req,
  input logic          xfer,
  input logic          burst,
  input logic          last,
  input logic [AW-1:0] addr,
  input logic [3:0]    be_n,
  input logic          busy
);
  // R2
  burst_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && burst) |-> be_n == 4'b0000);

  // R7
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && last) |=> (!req && !xfer));

  // R6
  preempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gnt |-> !xfer);

  // R4
  fifo_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rx_q && rx_words == '0) |-> !xfer);

  // R8
  tail_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !burst) |-> (last && be_n != 4'b0000 && be_n != 4'b1111));

  // R9
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> (!busy || addr == $past(addr) + 32'd4));

  // R10
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!req && !xfer && be_n == 4'b1111));
endmodule

bind dma_burst_seq dma_burst_seq_chk #(.AW(AW), .FW(FW)) u_chk (
  .clk(clk), .rst_n(rst_n), .gnt(gnt), .rx_q(rx_q), .rx_words(rx_words),
  .req(req), .xfer(xfer), .burst(burst), .last(last), .addr(addr),
  .be_n(be_n), .busy(busy)
);

// File: tb/dma_burst_seq_bench.sv
module dma_burst_seq_bench;
  localparam int PERIOD = 10;

  typedef struct packed {
    logic        rx;
    logic [15:0] base;
    logic [15:0] fin;
    logic [7:0]  lim;
    logic [7:0]  nx;
    logic [7:0]  nlast;
    logic [7:0]  nsing;
    logic [3:0]  be;
  } vec_t;

  localparam vec_t TABLE [8] = '{
    '{1'b0, 16'h0100, 16'h011F, 8'd4, 8'd8, 8'd2, 8'd0, 4'hF},
    '{1'b0, 16'h0200, 16'h0213, 8'd2, 8'd5, 8'd3, 8'd0, 4'hF},
    '{1'b1, 16'h0300, 16'h031F, 8'd8, 8'd8, 8'd1, 8'd0, 4'hF},
    '{1'b1, 16'h0400, 16'h0411, 8'd8, 8'd5, 8'd2, 8'd1, 4'hC},
    '{1'b1, 16'h0500, 16'h0508, 8'd2, 8'd3, 8'd2, 8'd1, 4'hE},
    '{1'b1, 16'h0600, 16'h0602, 8'd4, 8'd1, 8'd1, 8'd1, 4'h8},
    '{1'b0, 16'h0700, 16'h0702, 8'd4, 8'd1, 8'd1, 8'd0, 4'hF},
    '{1'b1, 16'h0800, 16'h080B, 8'd0, 8'd3, 8'd3, 8'd0, 4'hF}
  };

  logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0, rx_mode = 1'b0, gnt = 1'b0;
  logic [31:0] buf_base = '0, buf_end = '0;
  logic [7:0]  burst_limit = 8'd1, rx_words = 8'd200;
  logic        req, xfer, burst, last, busy;
  logic [31:0] addr;
  logic [3:0]  be_n;

  int checks = 0, errors = 0;
  int n_x, n_last, n_sing, run, eff_lim;
  logic [31:0] exp_addr;
  logic [3:0]  sing_be;
  logic        prev_last;

  always #(PERIOD/2) clk = ~clk;

  dma_burst_seq u_dma_burst_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .rx_mode(rx_mode),
    .buf_base(buf_base), .buf_end(buf_end), .burst_limit(burst_limit),
    .rx_words(rx_words), .gnt(gnt), .req(req), .xfer(xfer), .burst(burst),
    .last(last), .addr(addr), .be_n(be_n), .busy(busy)
  );

  task automatic chk(input bit ok, input string req_tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req_tag, act, exp);
    end
  endtask

  task automatic monitor();
    if (prev_last) chk(!xfer && !req, "R7 release after last", {req, xfer}, 0);
    if (!gnt) begin
      chk(!xfer, "R6 no transfer without grant", xfer, 0);
      run = 0;
    end
    if (rx_mode && busy && rx_words == 0) chk(!xfer, "R4 empty fifo", xfer, 0);
    if (xfer) begin
      chk(addr == exp_addr, "R9 address", addr, exp_addr);
      exp_addr += 4;
      n_x++;
      run++;
      chk(run <= eff_lim, "R1 burst length", run, eff_lim);
      if (burst) chk(be_n == 4'b0000, "R2 burst lanes", be_n, 0);
      else begin n_sing++; sing_be = be_n; end
      if (rx_mode && rx_words == 1) chk(last, "R4 fifo final word", last, 1);
      if (last) begin n_last++; run = 0; end
    end
    prev_last = xfer && last;
  endtask

  task automatic tick();
    #2;
    monitor();
    @(posedge clk);
    #1;
  endtask

  task automatic begin_job(input logic rx, input logic [31:0] b, input logic [31:0] e, input logic [7:0] l);
    rx_mode = rx; buf_base = b; buf_end = e; burst_limit = l;
    eff_lim = (l == 0) ? 1 : int'(l);
    exp_addr = {b[31:2], 2'b00};
    n_x = 0; n_last = 0; n_sing = 0; run = 0; prev_last = 1'b0; sing_be = 4'hF;
    start = 1'b1;
    tick();
    start = 1'b0;
  endtask

  task automatic finish_job();
    for (int i = 0; i < 500 && busy; i++) tick();
    chk(!busy, "R3 job completes", busy, 0);
  endtask

  initial begin
    #(PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(PERIOD * 2 + 1);
    chk(!busy && !req && !xfer && be_n == 4'hF, "R10 reset state", {busy, req, xfer, be_n}, 32'h0F);
    rst_n = 1'b1;
    @(posedge clk); #1;
    gnt = 1'b1;

    for (int v = 0; v < 8; v++) begin
      begin_job(TABLE[v].rx, {16'h0, TABLE[v].base}, {16'h0, TABLE[v].fin}, TABLE[v].lim);
      finish_job();
      chk(n_x == int'(TABLE[v].nx), "R5 transfer count", n_x, TABLE[v].nx);
      chk(n_last == int'(TABLE[v].nlast), "R1 R8 released bursts", n_last, TABLE[v].nlast);
      chk(n_sing == int'(TABLE[v].nsing), "R8 R11 single cycles", n_sing, TABLE[v].nsing);
      chk(sing_be == TABLE[v].be, "R8 tail byte enables", sing_be, TABLE[v].be);
      chk(exp_addr == {16'h0, TABLE[v].fin[15:2], 2'b00} + 4, "R5 end address", exp_addr, {16'h0, TABLE[v].fin[15:2], 2'b00} + 4);
    end

    // R6 R9: preemption mid-burst, resume
    begin_job(1'b0, 32'h900, 32'h93F, 8'd8);
    for (int i = 0; i < 50 && n_x < 3; i++) tick();
    gnt = 1'b0;
    for (int i = 0; i < 4; i++) tick();
    chk(n_x == 3, "R6 held while preempted", n_x, 3);
    gnt = 1'b1;
    finish_job();
    chk(n_x == 16, "R9 no loss after preemption", n_x, 16);
    chk(n_last == 2, "R6 burst restarts on regrant", n_last, 2);

    // R4: receive FIFO running dry
    rx_words = 8'd0;
    begin_job(1'b1, 32'hA00, 32'hA0F, 8'd8);
    for (int i = 0; i < 3; i++) tick();
    chk(n_x == 0 && busy, "R4 waits on empty fifo", n_x, 0);
    rx_words = 8'd1;
    for (int i = 0; i < 20 && n_x < 1; i++) tick();
    chk(n_last == 1, "R4 one-word fifo ends burst", n_last, 1);
    rx_words = 8'd5;
    finish_job();
    chk(n_x == 4 && n_last == 2, "R4 R5 fifo job totals", {n_x[15:0], n_last[15:0]}, {16'd4, 16'd2});

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule